// File: doc/BRIEF.md
# Converter sleep-mode run controller

This block decides, for every system power mode, whether an on-chip analog-to-digital converter may run. It also decides how the converter's clock and analog front end are requested. It decodes the current power mode and three control bits (enable, keep-running-in-sleep and power-on-demand) into a run policy. The policy is one of three values: forbidden, always-on, or on-demand. A Moore state machine then sequences the clock request, the analog power enable, a wake-up request to the power manager and a one-cycle conversion start strobe.

In always-on operation the clock and the front end stay granted, and a start trigger launches a conversion as soon as the front end reports ready. In on-demand operation everything stays powered off while the system sleeps. A trigger first raises a wake-up request together with the clock and power requests. The start is held back until the analog-ready input is seen, and the requests are released one cycle after the conversion reports done. A trigger that arrives while a conversion is running is remembered and served once the running conversion completes.

The states are OFF (nothing requested), READY (powered, waiting for a trigger), SETTLE (powered, waiting for readiness before a start), WAKE (wake-up raised, waiting for readiness), START (one-cycle start strobe) and CONVERT (waiting for done). The transitions are as follows:
- A forbidden policy sends every state to OFF.
- OFF goes to READY under an always-on policy, or to WAKE on a trigger under on-demand.
- READY goes to OFF when the policy turns on-demand. On a trigger it goes to START if the front end is ready, and to SETTLE if it is not.
- SETTLE and WAKE go to START when the front end is ready.
- START always goes to CONVERT.
- CONVERT, on done, goes to SETTLE if a trigger is pending. Otherwise it goes to READY under always-on, or to OFF under on-demand.

Top module: `adc_run_ctrl`

## Requirements
- R1: While the enable bit is 0, the next cycle shows clock request, analog enable, wake-up, start and busy all low, whatever the mode, the other bits or the trigger.
- R2: Mode codes 3 (hibernate), 4 (backup), 5 (off), and the unused codes 6 and 7, forbid running: all five outputs are low the cycle after such a mode is seen, and triggers have no effect.
- R3: In mode code 0 (active) with enable set, clock request and analog enable are high from the cycle after the mode is seen, whatever the other two bits. Wake-up is never raised.
- R4: In mode code 1 (idle) or 2 (standby), with enable=1, keep-running=0 and on-demand=0, nothing is requested and a trigger starts nothing.
- R5: In idle or standby with keep-running=1 and on-demand=0, clock request and analog enable stay high. A trigger with the front end ready gives a start strobe in the next cycle.
- R6: In idle or standby with on-demand=1 (either keep-running value), all outputs stay low until a trigger. The cycle after the trigger shows wake-up, clock request and analog enable high, with no start.
- R7: A start strobe is only given in the cycle after analog-ready was sampled high. While ready stays low after a trigger, the requests are held and no start appears.
- R8: The start strobe lasts exactly one cycle. Busy is high from the strobe until the cycle after conversion-done.
- R9: Under an on-demand policy with no trigger pending, clock request and analog enable drop in the cycle after conversion-done.
- R10: A trigger during a conversion is kept pending. After done, the requests stay high and a new start follows once the front end is ready.
- R11: When the policy becomes forbidden, the block returns to OFF in the next cycle and discards any pending trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | MODE_W | Power mode code: 0 active, 1 idle, 2 standby, 3 hibernate, 4 backup, 5 off, others off |
| cfg_en | input | 1 | Converter enable |
| cfg_keep_run | input | 1 | Keep running during idle and standby |
| cfg_on_demand | input | 1 | Power the front end only on request |
| evt_trig | input | 1 | Start trigger from the event routing fabric |
| afe_ready | input | 1 | Analog front end ready |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| clk_req | output | 1 | Converter clock request |
| afe_pwr_en | output | 1 | Analog front end power enable |
| wake_req | output | 1 | Wake-up request to the power manager |
| conv_start | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with MODE_W=3. This makes all eight mode codes reachable, including the two unused ones. Together with the three control bits it gives 64 configurations, and the bench sweeps every one of them through reset, an idle check, a trigger, the start and the done pulse. It predicts each output from a policy it computes for itself. Directed sequences then cover the cases the sweep cannot reach: a late ready in both the wake and settle paths, a pending trigger served under both policies, and aborts on mode or enable changes that must discard a pending trigger.

// File: rtl/adc_run_pkg.sv
package adc_run_pkg;

    // Mode codes; every code above PM_OFF is treated as off.
    localparam int PM_ACTIVE    = 0;
    localparam int PM_IDLE      = 1;
    localparam int PM_STANDBY   = 2;
    localparam int PM_HIBERNATE = 3;
    localparam int PM_BACKUP    = 4;
    localparam int PM_OFF       = 5;

    typedef enum logic [1:0] {
        POL_OFF    = 2'd0,
        POL_DEMAND = 2'd1,
        POL_ALWAYS = 2'd2
    } run_pol_e;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_READY   = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_WAKE    = 3'd3,
        ST_START   = 3'd4,
        ST_CONVERT = 3'd5
    } run_state_e;

    typedef struct packed {
        logic clk_req;
        logic afe_en;
        logic wake;
        logic start;
        logic busy;
    } run_out_t;

endpackage

// File: rtl/adc_run_policy.sv
module adc_run_policy
    import adc_run_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              cfg_en,
    input  logic              cfg_keep_run,
    input  logic              cfg_on_demand,
    output run_pol_e          pol
);

    localparam logic [MODE_W-1:0] M_ACTIVE  = MODE_W'(PM_ACTIVE);
    localparam logic [MODE_W-1:0] M_IDLE    = MODE_W'(PM_IDLE);
    localparam logic [MODE_W-1:0] M_STANDBY = MODE_W'(PM_STANDBY);

    logic in_sleep;
    logic in_active;

    always_comb begin
        in_active = (mode == M_ACTIVE);
        in_sleep  = (mode == M_IDLE) || (mode == M_STANDBY);
    end

    always_comb begin
        pol = POL_OFF;
        if (!cfg_en) begin
            pol = POL_OFF;
        end else if (in_active) begin
            pol = POL_ALWAYS;
        end else if (in_sleep) begin
            if (cfg_on_demand)
                pol = POL_DEMAND;
            else if (cfg_keep_run)
                pol = POL_ALWAYS;
            else
                pol = POL_OFF;
        end
    end

endmodule

// File: rtl/adc_run_pend.sv
module adc_run_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
    end

    a_r10_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    a_r11_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);

endmodule

// File: rtl/adc_run_fsm.sv
module adc_run_fsm
    import adc_run_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  run_pol_e   pol,
    input  logic       trig,
    input  logic       ready,
    input  logic       done,
    input  logic       pend,
    output run_state_e state,
    output run_state_e nxt,
    output run_out_t   outs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (pol == POL_OFF) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (pol == POL_ALWAYS)
                        nxt = ST_READY;
                    else if (trig)
                        nxt = ST_WAKE;
                end
                ST_READY: begin
                    if (pol == POL_DEMAND)
                        nxt = ST_OFF;
                    else if (trig)
                        nxt = ready ? ST_START : ST_SETTLE;
                end
                ST_SETTLE, ST_WAKE: begin
                    if (ready)
                        nxt = ST_START;
                end
                ST_START: begin
                    nxt = ST_CONVERT;
                end
                ST_CONVERT: begin
                    if (done) begin
                        if (pend)
                            nxt = ST_SETTLE;
                        else if (pol == POL_ALWAYS)
                            nxt = ST_READY;
                        else
                            nxt = ST_OFF;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        outs = '0;
        unique case (state)
            ST_OFF:     outs = '0;
            ST_READY:   begin outs.clk_req = 1'b1; outs.afe_en = 1'b1; end
            ST_SETTLE:  begin outs.clk_req = 1'b1; outs.afe_en = 1'b1; end
            ST_WAKE:    begin outs.clk_req = 1'b1; outs.afe_en = 1'b1; outs.wake = 1'b1; end
            ST_START:   begin outs.clk_req = 1'b1; outs.afe_en = 1'b1;
                              outs.start = 1'b1; outs.busy = 1'b1; end
            ST_CONVERT: begin outs.clk_req = 1'b1; outs.afe_en = 1'b1; outs.busy = 1'b1; end
            default:    outs = '0;
        endcase
    end

    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |=> (state == ST_CONVERT) || (state == ST_OFF));

    a_r7_start_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SETTLE || state == ST_WAKE) && !ready) |=> (state != ST_START));

endmodule

// File: rtl/adc_run_ctrl.sv
module adc_run_ctrl
    import adc_run_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] pwr_mode,
    input  logic              cfg_en,
    input  logic              cfg_keep_run,
    input  logic              cfg_on_demand,
    input  logic              evt_trig,
    input  logic              afe_ready,
    input  logic              conv_done,
    output logic              clk_req,
    output logic              afe_pwr_en,
    output logic              wake_req,
    output logic              conv_start,
    output logic              busy
);

    run_pol_e   pol;
    run_state_e state;
    run_state_e nxt;
    run_out_t   outs;
    logic       pend;
    logic       pend_set;
    logic       pend_clr;

    adc_run_policy #(.MODE_W(MODE_W)) u_policy (
        .mode          (pwr_mode),
        .cfg_en        (cfg_en),
        .cfg_keep_run  (cfg_keep_run),
        .cfg_on_demand (cfg_on_demand),
        .pol           (pol)
    );

    always_comb begin
        pend_set = evt_trig && outs.busy;
        pend_clr = (pol == POL_OFF) || (nxt == ST_START);
    end

    adc_run_pend u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pend_set),
        .clr   (pend_clr),
        .pend  (pend)
    );

    adc_run_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pol   (pol),
        .trig  (evt_trig),
        .ready (afe_ready),
        .done  (conv_done),
        .pend  (pend),
        .state (state),
        .nxt   (nxt),
        .outs  (outs)
    );

    always_comb begin
        clk_req    = outs.clk_req;
        afe_pwr_en = outs.afe_en;
        wake_req   = outs.wake;
        conv_start = outs.start;
        busy       = outs.busy;
    end

    a_r1_r2_forbidden_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_OFF) |=> !clk_req && !afe_pwr_en && !wake_req && !conv_start && !busy);

    a_r3_r5_always_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_ALWAYS) |=> clk_req && afe_pwr_en);

    a_r7_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> $past(afe_ready));

    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start && busy);

    a_r6_wake_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> clk_req && afe_pwr_en && !conv_start && !busy);

    a_r9_demand_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_DEMAND && busy && !conv_start && conv_done && !pend)
            |=> !clk_req && !afe_pwr_en);

endmodule

// File: tb/adc_run_ctrl_bench.sv
module adc_run_ctrl_bench;

    localparam int MODE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MODE_W-1:0] pwr_mode = '0;
    logic              cfg_en = 1'b0;
    logic              cfg_keep_run = 1'b0;
    logic              cfg_on_demand = 1'b0;
    logic              evt_trig = 1'b0;
    logic              afe_ready = 1'b0;
    logic              conv_done = 1'b0;
    logic              clk_req, afe_pwr_en, wake_req, conv_start, busy;

    int nchecks = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    adc_run_ctrl #(.MODE_W(MODE_W)) u_adc_run_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_mode      (pwr_mode),
        .cfg_en        (cfg_en),
        .cfg_keep_run  (cfg_keep_run),
        .cfg_on_demand (cfg_on_demand),
        .evt_trig      (evt_trig),
        .afe_ready     (afe_ready),
        .conv_done     (conv_done),
        .clk_req       (clk_req),
        .afe_pwr_en    (afe_pwr_en),
        .wake_req      (wake_req),
        .conv_start    (conv_start),
        .busy          (busy)
    );

    // Output vector order: clk_req, afe_pwr_en, wake_req, conv_start, busy
    localparam logic [4:0] O_NONE  = 5'b00000;
    localparam logic [4:0] O_PWR   = 5'b11000;
    localparam logic [4:0] O_WAKE  = 5'b11100;
    localparam logic [4:0] O_START = 5'b11011;
    localparam logic [4:0] O_CONV  = 5'b11001;

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {clk_req, afe_pwr_en, wake_req, conv_start, busy};
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %b expected %b (clk,afe,wake,start,busy)", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        evt_trig = 1'b0;
        conv_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // 0 forbidden, 1 on-demand, 2 always-on
    function automatic int exp_pol(int m, bit en, bit kr, bit od);
        if (!en || m >= 3) return 0;
        if (m == 0) return 2;
        if (od) return 1;
        if (kr) return 2;
        return 0;
    endfunction

    function automatic string exp_tag(int m, bit en, bit kr, bit od);
        if (!en) return "R1";
        if (m >= 3) return "R2";
        if (m == 0) return "R3";
        if (od) return "R6";
        if (kr) return "R5";
        return "R4";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        // Reset state
        #1;
        chk("reset R1", O_NONE);

        // Sweep all mode codes and control-bit combinations
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 8; b++) begin
                int    p;
                string t;
                p = exp_pol(m, b[2], b[1], b[0]);
                t = exp_tag(m, b[2], b[1], b[0]);
                pwr_mode = MODE_W'(m);
                cfg_en = b[2];
                cfg_keep_run = b[1];
                cfg_on_demand = b[0];
                afe_ready = 1'b1;
                do_reset();
                tick();
                tick();
                chk({t, " idle"}, (p == 2) ? O_PWR : O_NONE);
                @(negedge clk) evt_trig = 1'b1;
                tick();
                chk({t, " trigger"}, (p == 2) ? O_START : (p == 1) ? O_WAKE : O_NONE);
                @(negedge clk) evt_trig = 1'b0;
                if (p == 1) begin
                    tick();
                    chk({t, " R7 start after wake"}, O_START);
                    @(negedge clk);
                end
                if (p != 0) begin
                    tick();
                    chk({t, " R8 converting"}, O_CONV);
                    @(negedge clk);
                end
                conv_done = 1'b1;
                tick();
                chk({t, (p == 1) ? " R9 release" : " R8 done"}, (p == 2) ? O_PWR : O_NONE);
                @(negedge clk) conv_done = 1'b0;
            end
        end

        // R7: on-demand wake with a late ready, then abort on hibernate (R2, R11)
        pwr_mode = 3'd2; cfg_en = 1'b1; cfg_keep_run = 1'b1; cfg_on_demand = 1'b1;
        afe_ready = 1'b0;
        do_reset();
        tick();
        chk("R6 off before trigger", O_NONE);
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R6 wake raised", O_WAKE);
        @(negedge clk) evt_trig = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7 held while not ready", O_WAKE);
        end
        @(negedge clk) pwr_mode = 3'd3;
        tick();
        chk("R11 abort on hibernate", O_NONE);
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R2 trigger ignored in hibernate", O_NONE);
        @(negedge clk) begin evt_trig = 1'b0; pwr_mode = 3'd1; end
        tick();
        chk("R6 idle stays off", O_NONE);
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R6 wake in idle", O_WAKE);
        @(negedge clk) begin evt_trig = 1'b0; afe_ready = 1'b1; end
        tick();
        chk("R7 start once ready", O_START);

        // R5/R7: keep-running path with ready low goes through settle
        pwr_mode = 3'd2; cfg_en = 1'b1; cfg_keep_run = 1'b1; cfg_on_demand = 1'b0;
        afe_ready = 1'b0;
        do_reset();
        tick();
        chk("R5 powered in standby", O_PWR);
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R7 settle no start", O_PWR);
        @(negedge clk) evt_trig = 1'b0;
        tick();
        chk("R7 still settling", O_PWR);
        @(negedge clk) afe_ready = 1'b1;
        tick();
        chk("R7 start after ready", O_START);

        // R10: pending trigger under always-on
        pwr_mode = 3'd0; cfg_en = 1'b1; cfg_keep_run = 1'b0; cfg_on_demand = 1'b0;
        afe_ready = 1'b1;
        do_reset();
        tick();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R3 start in active", O_START);
        @(negedge clk) evt_trig = 1'b0;
        tick();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        chk("R10 trigger during conversion", O_CONV);
        @(negedge clk) begin evt_trig = 1'b0; conv_done = 1'b1; end
        tick();
        chk("R10 settle after done", O_PWR);
        @(negedge clk) conv_done = 1'b0;
        tick();
        chk("R10 pending served", O_START);
        tick();
        @(negedge clk) conv_done = 1'b1;
        tick();
        chk("R8 busy drops after done", O_PWR);
        @(negedge clk) conv_done = 1'b0;
        tick();
        chk("R10 pending consumed", O_PWR);

        // R10 under on-demand: requests kept across the pending turnaround
        pwr_mode = 3'd1; cfg_en = 1'b1; cfg_keep_run = 1'b0; cfg_on_demand = 1'b1;
        afe_ready = 1'b1;
        do_reset();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        @(negedge clk) evt_trig = 1'b0;
        tick();
        tick();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        @(negedge clk) begin evt_trig = 1'b0; conv_done = 1'b1; end
        tick();
        chk("R10 demand requests kept", O_PWR);
        @(negedge clk) conv_done = 1'b0;
        tick();
        chk("R10 demand pending start", O_START);
        tick();
        @(negedge clk) conv_done = 1'b1;
        tick();
        chk("R9 demand release", O_NONE);
        @(negedge clk) conv_done = 1'b0;

        // R11 / R1: disabling mid-conversion discards the pending trigger
        pwr_mode = 3'd0; cfg_en = 1'b1; cfg_keep_run = 1'b0; cfg_on_demand = 1'b0;
        do_reset();
        tick();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        @(negedge clk) evt_trig = 1'b0;
        tick();
        @(negedge clk) evt_trig = 1'b1;
        tick();
        @(negedge clk) begin evt_trig = 1'b0; cfg_en = 1'b0; end
        tick();
        chk("R1 disable aborts", O_NONE);
        @(negedge clk) cfg_en = 1'b1;
        tick();
        chk("R11 re-enabled ready", O_PWR);
        tick();
        chk("R11 pending discarded", O_PWR);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule